// File: doc/BRIEF.md
# Double-Buffered DMA Channel

This block is a single DMA channel that streams transfer units between a memory buffer and one peripheral FIFO address. It holds two buffer descriptors, each a start address and a unit count, and works through them in ping-pong order. Software fills one descriptor while the channel drains the other. A completed buffer raises its done flag, loses its enable and hands over to its partner. If the partner is not enabled, the channel waits for it.

Software reaches the channel through a small register window. The mode register has one write offset that sets bits and another that clears them, so a driver can change a single control bit without a read-modify-write. Stopping the channel is a handshake: software drops GO, then polls HALT. HALT rises only after the beat in flight has been accepted. The endianness, coherency, transfer-size, device-select and device-ID bits are stored and read back. They have no effect inside the block.

Each transfer is one beat. It is presented at the same time to the memory side and the peripheral side, and it completes in the cycle where both sides acknowledge it.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset the mode register reads 0x00000040 (only HALT set), all descriptor registers read 0, `mem_req`, `dev_req` and `irq` are 0.
- R2: A write to offset 0x00 sets every mode bit written as 1, and a write to offset 0x04 clears every mode bit written as 1. Bits written as 0 are unchanged. Bit 6 (HALT), bit 14 and bits 31:24 ignore both writes. Bit 14 and bits 31:24 read 0.
- R3: `mem_req` is high while GO (bit 5) is set, the enable of the active buffer is set (bit 0 for buffer 0, bit 2 for buffer 1) and its count is non-zero. A beat is accepted in a cycle where `mem_req`, `mem_ack` and `dev_ack` are all high. Each accepted beat decrements the active count by one and advances the active address by 1, 2 or 4 bytes for width code 0, 1 or 2 in mode bits 10:9. `beat_size` shows that width code. `mem_addr` is the buffer's high nibble (count register bits 19:16) followed by its 28-bit address.
- R4: When the active buffer's count is zero while GO and its enable are set, the channel clears that enable, sets its done flag (bit 1 for buffer 0, bit 3 for buffer 1) and inverts the active-buffer bit (bit 4: 0 for buffer 0, 1 for buffer 1). A buffer enabled with a count of zero completes with no beat.
- R5: After buffer 0 completes, transfers continue from buffer 1's address and count if its enable is set. If it is not set, `mem_req` stays low until software sets it, and then buffer 1 runs.
- R6: HALT reads 0 while GO is set. After GO is cleared, a beat already requested keeps `mem_req` high with a stable `mem_addr` until it is accepted. HALT reads 1 only once `mem_req` is low.
- R7: `irq` is high exactly when IE (bit 7) is set and at least one done flag is set.
- R8: Offsets 0x0C/0x14 read the buffer 0/1 address and 0x10/0x18 read the buffer 0/1 count in bits 15:0 with the high nibble in bits 19:16. The active count reads its live remaining value. Offset 0x08 holds the peripheral address.
- R9: `dev_addr` is mode bits 23:20 followed by the 28-bit peripheral address. With bit 12 set, `mem_we` is 1 and `mem_wdata` equals `dev_rdata`. With bit 12 clear, `dev_we` is 1 and `dev_wdata` equals `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory beat request |
| mem_addr | output | 32 | Memory byte address |
| mem_we | output | 1 | Memory write (peripheral-to-memory direction) |
| mem_wdata | output | 32 | Data written to memory |
| mem_rdata | input | 32 | Data read from memory |
| mem_ack | input | 1 | Memory side accepts the beat |
| dev_req | output | 1 | Peripheral beat request |
| dev_addr | output | 32 | Peripheral FIFO address |
| dev_we | output | 1 | Peripheral write (memory-to-peripheral direction) |
| dev_wdata | output | 32 | Data written to the peripheral |
| dev_rdata | input | 32 | Data read from the peripheral |
| dev_ack | input | 1 | Peripheral side accepts the beat |
| beat_size | output | 2 | Width code of the current unit |
| irq | output | 1 | Buffer-done interrupt |

## Verification
The bench runs a zero-length buffer. A design that waits for a beat before completing would hang there, and one that decrements past zero would wrap the count to 0xFFFF. It stalls the peripheral acknowledge and then drops GO. A design that abandons the pending beat, or that reports HALT too early, shows a moving address or HALT set while `mem_req` is still high. It runs back-to-back ping-pong, and also a partner that is enabled late. A design that ignores the partner's enable would issue beats from an unprogrammed descriptor, and one that forgets to toggle the active bit would replay buffer 0. Address steps are checked for all three widths, so a wrong shift shows up as a wrong address.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;

  localparam int REG_AW = 5;
  localparam int MODE_W = 24;
  localparam int HI_W   = 4;

  localparam logic [REG_AW-1:0] OFS_MODE_SET = 5'h00;
  localparam logic [REG_AW-1:0] OFS_MODE_CLR = 5'h04;
  localparam logic [REG_AW-1:0] OFS_PER      = 5'h08;
  localparam logic [REG_AW-1:0] OFS_ADR0     = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_CNT0     = 5'h10;
  localparam logic [REG_AW-1:0] OFS_ADR1     = 5'h14;
  localparam logic [REG_AW-1:0] OFS_CNT1     = 5'h18;

  localparam int B_EN0  = 0;
  localparam int B_DN0  = 1;
  localparam int B_EN1  = 2;
  localparam int B_DN1  = 3;
  localparam int B_ACT  = 4;
  localparam int B_GO   = 5;
  localparam int B_HALT = 6;
  localparam int B_IE   = 7;
  localparam int B_DW   = 9;
  localparam int B_DIR  = 12;
  localparam int B_PHI  = 20;
  localparam int B_BHI  = 16;

  // bits software may touch: all but HALT (6) and the hole at 14
  localparam logic [MODE_W-1:0] SW_MASK = 24'hFFBFBF;

  function automatic logic [1:0] size_log2(input logic [1:0] dw);
    if (dw == 2'd0)      return 2'd0;
    else if (dw == 2'd1) return 2'd1;
    else                 return 2'd2;
  endfunction

endpackage

// File: rtl/dbuf_dma_desc.sv
module dbuf_dma_desc #(
  parameter int LOW_AW = 28,
  parameter int CNT_W  = 16,
  parameter int HI_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adr_we,
  input  logic              cnt_we,
  input  logic [LOW_AW-1:0] adr_wdata,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic [HI_W-1:0]   hi_wdata,
  input  logic              beat,
  input  logic [2:0]        step,
  output logic [LOW_AW-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [HI_W-1:0]   hi_q,
  output logic [CNT_W-1:0]  cnt_d
);

  logic [LOW_AW-1:0] addr_d;
  logic [HI_W-1:0]   hi_d;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    hi_d   = hi_q;
    if (adr_we)    addr_d = adr_wdata;
    else if (beat) addr_d = addr_q + LOW_AW'(step);
    if (cnt_we) begin
      cnt_d = cnt_wdata;
      hi_d  = hi_wdata;
    end else if (beat) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      hi_q   <= '0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      hi_q   <= hi_d;
    end
  end

endmodule

// File: rtl/dbuf_dma_mode.sv
module dbuf_dma_mode
  import dbuf_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [MODE_W-1:0] wdata,
  input  logic              complete,
  output logic [MODE_W-1:0] mode_q,
  output logic [MODE_W-1:0] mode_d
);

  logic [MODE_W-1:0] wmask;

  always_comb begin
    wmask  = wdata & SW_MASK;
    mode_d = mode_q;
    if (set_we) mode_d = mode_d | wmask;
    if (clr_we) mode_d = mode_d & ~wmask;
    // hardware completion has the last word on the bits it owns
    if (complete) begin
      if (mode_q[B_ACT]) begin
        mode_d[B_EN1] = 1'b0;
        mode_d[B_DN1] = 1'b1;
      end else begin
        mode_d[B_EN0] = 1'b0;
        mode_d[B_DN0] = 1'b1;
      end
      mode_d[B_ACT] = ~mode_q[B_ACT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

endmodule

// File: rtl/dbuf_dma_engine.sv
module dbuf_dma_engine #(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_q,
  input  logic [1:0]            en_q,
  input  logic                  act_q,
  input  logic                  go_n,
  input  logic [1:0]            en_n,
  input  logic                  act_n,
  input  logic [1:0][CNT_W-1:0] cnt_q,
  input  logic [1:0][CNT_W-1:0] cnt_d,
  input  logic                  mem_ack,
  input  logic                  dev_ack,
  output logic                  req_q,
  output logic                  beat,
  output logic                  complete,
  output logic                  halt_q
);

  logic req_d;
  logic halt_d;
  logic act_empty;
  logic nxt_ready;

  always_comb begin
    beat      = req_q & mem_ack & dev_ack;
    act_empty = (cnt_q[act_q] == '0);
    complete  = go_q & en_q[act_q] & act_empty & ~req_q;
    nxt_ready = go_n & en_n[act_n] & (cnt_d[act_n] != '0);
    // a requested beat is never withdrawn
    req_d     = (req_q & ~beat) | nxt_ready;
    halt_d    = ~go_n & ~req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      halt_q <= 1'b1;
    end else begin
      req_q  <= req_d;
      halt_q <= halt_d;
    end
  end

endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbuf_dma_pkg::*;
#(
  parameter int LOW_AW = 28,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  localparam int OUT_AW = LOW_AW + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [OUT_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              dev_req,
  output logic [OUT_AW-1:0] dev_addr,
  output logic              dev_we,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic              dev_ack,
  output logic [1:0]        beat_size,
  output logic              irq
);

  logic [MODE_W-1:0]          mode_q;
  logic [MODE_W-1:0]          mode_d;
  logic [LOW_AW-1:0]          per_q;
  logic [LOW_AW-1:0]          per_d;
  logic [1:0][LOW_AW-1:0]     addr_q;
  logic [1:0][CNT_W-1:0]      cnt_q;
  logic [1:0][CNT_W-1:0]      cnt_d;
  logic [1:0][HI_W-1:0]       hi_q;
  logic                       req_q;
  logic                       beat;
  logic                       complete;
  logic                       halt_q;
  logic                       act_q;
  logic [CNT_W-1:0]           act_cnt;
  logic [2:0]                 step;
  logic                       set_we;
  logic                       clr_we;
  logic                       per_we;
  logic                       unused_wdata;

  assign unused_wdata = ^reg_wdata[31:24];

  assign set_we = reg_wr & (reg_addr == OFS_MODE_SET);
  assign clr_we = reg_wr & (reg_addr == OFS_MODE_CLR);
  assign per_we = reg_wr & (reg_addr == OFS_PER);

  assign act_q     = mode_q[B_ACT];
  assign act_cnt   = cnt_q[act_q];
  assign beat_size = size_log2(mode_q[B_DW+1:B_DW]);
  assign step      = 3'd1 << beat_size;

  dbuf_dma_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .wdata    (reg_wdata[MODE_W-1:0]),
    .complete (complete),
    .mode_q   (mode_q),
    .mode_d   (mode_d)
  );

  generate
    for (genvar i = 0; i < 2; i++) begin : g_buf
      localparam logic [REG_AW-1:0] A_OFS = (i == 0) ? OFS_ADR0 : OFS_ADR1;
      localparam logic [REG_AW-1:0] C_OFS = (i == 0) ? OFS_CNT0 : OFS_CNT1;
      logic buf_beat;
      assign buf_beat = beat & (act_q == 1'(i));
      dbuf_dma_desc #(
        .LOW_AW (LOW_AW),
        .CNT_W  (CNT_W),
        .HI_W   (HI_W)
      ) u_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .adr_we    (reg_wr & (reg_addr == A_OFS)),
        .cnt_we    (reg_wr & (reg_addr == C_OFS)),
        .adr_wdata (reg_wdata[LOW_AW-1:0]),
        .cnt_wdata (reg_wdata[CNT_W-1:0]),
        .hi_wdata  (reg_wdata[B_BHI+HI_W-1:B_BHI]),
        .beat      (buf_beat),
        .step      (step),
        .addr_q    (addr_q[i]),
        .cnt_q     (cnt_q[i]),
        .hi_q      (hi_q[i]),
        .cnt_d     (cnt_d[i])
      );
    end
  endgenerate

  dbuf_dma_engine #(
    .CNT_W (CNT_W)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_q     (mode_q[B_GO]),
    .en_q     ({mode_q[B_EN1], mode_q[B_EN0]}),
    .act_q    (act_q),
    .go_n     (mode_d[B_GO]),
    .en_n     ({mode_d[B_EN1], mode_d[B_EN0]}),
    .act_n    (mode_d[B_ACT]),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .mem_ack  (mem_ack),
    .dev_ack  (dev_ack),
    .req_q    (req_q),
    .beat     (beat),
    .complete (complete),
    .halt_q   (halt_q)
  );

  // peripheral address register
  always_comb begin
    per_d = per_q;
    if (per_we) per_d = reg_wdata[LOW_AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= '0;
    else        per_q <= per_d;
  end

  // register read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_MODE_SET: begin
        reg_rdata[MODE_W-1:0] = mode_q;
        reg_rdata[B_HALT]     = halt_q;
      end
      OFS_PER:  reg_rdata[LOW_AW-1:0] = per_q;
      OFS_ADR0: reg_rdata[LOW_AW-1:0] = addr_q[0];
      OFS_ADR1: reg_rdata[LOW_AW-1:0] = addr_q[1];
      OFS_CNT0: begin
        reg_rdata[CNT_W-1:0]           = cnt_q[0];
        reg_rdata[B_BHI+HI_W-1:B_BHI]  = hi_q[0];
      end
      OFS_CNT1: begin
        reg_rdata[CNT_W-1:0]           = cnt_q[1];
        reg_rdata[B_BHI+HI_W-1:B_BHI]  = hi_q[1];
      end
      default: reg_rdata = '0;
    endcase
  end

  assign mem_req   = req_q;
  assign dev_req   = req_q;
  assign mem_addr  = {hi_q[act_q], addr_q[act_q]};
  assign dev_addr  = {mode_q[B_PHI+HI_W-1:B_PHI], per_q};
  assign mem_we    = mode_q[B_DIR];
  assign dev_we    = ~mode_q[B_DIR];
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
  assign irq       = mode_q[B_IE] & (mode_q[B_DN0] | mode_q[B_DN1]);

endmodule

// File: rtl/dbuf_dma_chk.sv
module dbuf_dma_chk #(
  parameter int CNT_W  = 16,
  parameter int OUT_AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              dev_ack,
  input logic [OUT_AW-1:0] mem_addr,
  input logic              halt,
  input logic              act,
  input logic [CNT_W-1:0]  act_cnt,
  input logic              complete,
  input logic              ie,
  input logic              irq
);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !(mem_ack && dev_ack) && !reg_wr) |=> (mem_req && $stable(mem_addr)));

  assert_halt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !mem_req);

  assert_req_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (act_cnt != '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && dev_ack && !reg_wr) |=> (act_cnt == $past(act_cnt) - CNT_W'(1)));

  assert_done_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !reg_wr) |=> (act != $past(act)));

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie);

endmodule

bind dbuf_dma_chan dbuf_dma_chk #(
  .CNT_W  (CNT_W),
  .OUT_AW (OUT_AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .dev_ack  (dev_ack),
  .mem_addr (mem_addr),
  .halt     (halt_q),
  .act      (act_q),
  .act_cnt  (act_cnt),
  .complete (complete),
  .ie       (mode_q[7]),
  .irq      (irq)
);

// File: tb/dbuf_dma_chan_tb_top.sv
module dbuf_dma_chan_tb_top;

  localparam logic [4:0] A_SET = 5'h00, A_CLR = 5'h04, A_PER = 5'h08;
  localparam logic [4:0] A_AD0 = 5'h0C, A_CN0 = 5'h10, A_AD1 = 5'h14, A_CN1 = 5'h18;
  localparam logic [31:0] M_EN0 = 32'h1, M_DN0 = 32'h2, M_EN1 = 32'h4, M_DN1 = 32'h8;
  localparam logic [31:0] M_GO = 32'h20, M_IE = 32'h80, M_DIR = 32'h1000;

  typedef struct packed {
    logic [1:0]  dw;
    logic [15:0] cnt;
    logic [27:0] base;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 16'd5, 28'h0000100},
    '{2'd1, 16'd3, 28'h0000200},
    '{2'd2, 16'd4, 28'h0001000},
    '{2'd2, 16'd0, 28'h0000040}
  };

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_req, dev_we, dev_ack;
  logic [31:0] dev_addr, dev_wdata, dev_rdata;
  logic [1:0]  beat_size;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nbeat = 0;
  logic [31:0] log_addr [64];

  dbuf_dma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .dev_req(dev_req), .dev_addr(dev_addr), .dev_we(dev_we),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ack(dev_ack),
    .beat_size(beat_size), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack && dev_ack) begin
      if (nbeat < 64) log_addr[nbeat] = mem_addr;
      nbeat = nbeat + 1;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_mode(input int bitpos, input string tag);
    logic [31:0] m;
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < 300 && !seen; k++) begin
      rd(A_SET, m);
      if (m[bitpos]) seen = 1'b1;
    end
    check(tag, 32'(seen), 32'd1);
  endtask

  logic [31:0] v;
  int b0;

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    mem_ack = 1'b1; dev_ack = 1'b1;
    mem_rdata = 32'h1234ABCD; dev_rdata = 32'hCAFEF00D;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_SET, v); check("R1 mode after reset", v, 32'h00000040);
    rd(A_CN0, v); check("R1 count0 after reset", v, 32'h0);
    rd(A_AD1, v); check("R1 addr1 after reset", v, 32'h0);
    check("R1 mem_req after reset", 32'(mem_req), 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);

    // R2 set/clear ports
    wr(A_SET, 32'hFFFFFF80);
    rd(A_SET, v); check("R2 set port", v, 32'h00FFBFC0);
    wr(A_CLR, 32'h0000F000);
    rd(A_SET, v); check("R2 clear port", v, 32'h00FF0FC0);
    wr(A_CLR, 32'hFFFFFFFF);
    rd(A_SET, v); check("R2 clear all, HALT kept", v, 32'h00000040);

    // R3/R4/R7/R8 vector table on buffer 0
    for (int i = 0; i < NVEC; i++) begin
      wr(A_CLR, 32'hFFFFFFFF);
      wait_mode(6, "R6 halt before vector");
      b0 = nbeat;
      wr(A_AD0, {4'h0, VEC[i].base});
      wr(A_CN0, {12'h0, 4'h3, VEC[i].cnt});
      wr(A_SET, (32'(VEC[i].dw) << 9) | M_IE | M_EN0);
      wr(A_SET, M_GO);
      wait_mode(1, "R4 done0 reached");
      check("R3 beat count", 32'(nbeat - b0), 32'(VEC[i].cnt));
      for (int k = 0; k < int'(VEC[i].cnt); k++)
        check("R3 beat address", log_addr[b0 + k],
              {4'h3, VEC[i].base + (28'(k) << VEC[i].dw)});
      check("R3 beat_size", 32'(beat_size), 32'(VEC[i].dw));
      rd(A_AD0, v); check("R3 final address", v, {4'h0, VEC[i].base + (28'(VEC[i].cnt) << VEC[i].dw)});
      rd(A_CN0, v); check("R8 count readback at end", v, 32'h00030000);
      rd(A_SET, v); check("R4 mode flags after done", v & 32'h7F, 32'h32);
      check("R7 irq with IE and done", 32'(irq), 32'h1);
      if (i == 0) begin
        wr(A_CLR, M_IE);
        check("R7 irq low without IE", 32'(irq), 32'h0);
        wr(A_SET, M_IE);
        check("R7 irq back with IE", 32'(irq), 32'h1);
        wr(A_CLR, M_DN0);
        check("R7 irq low after done cleared", 32'(irq), 32'h0);
      end
    end

    // R5 back-to-back ping-pong
    wr(A_CLR, 32'hFFFFFFFF);
    wait_mode(6, "R6 halt before ping-pong");
    b0 = nbeat;
    wr(A_AD0, 32'h300); wr(A_CN0, 32'd2);
    wr(A_AD1, 32'h800); wr(A_CN1, 32'd3);
    wr(A_SET, (32'd2 << 9) | M_EN0 | M_EN1);
    wr(A_SET, M_GO);
    wait_mode(3, "R5 done1 reached");
    check("R5 ping-pong beats", 32'(nbeat - b0), 32'd5);
    check("R5 beat 0", log_addr[b0 + 0], 32'h300);
    check("R5 beat 1", log_addr[b0 + 1], 32'h304);
    check("R5 beat 2 from buffer 1", log_addr[b0 + 2], 32'h800);
    check("R5 beat 4", log_addr[b0 + 4], 32'h808);
    rd(A_SET, v); check("R5 mode flags after both", v & 32'h7F, 32'h2A);

    // R5 partner enabled late
    wr(A_CLR, 32'hFFFFFFFF);
    wait_mode(6, "R6 halt before idle test");
    b0 = nbeat;
    wr(A_AD0, 32'h40);  wr(A_CN0, 32'd1);
    wr(A_AD1, 32'h900); wr(A_CN1, 32'd2);
    wr(A_SET, M_EN0 | M_GO);
    wait_mode(1, "R5 done0 reached");
    repeat (8) @(negedge clk);
    check("R5 idle beats", 32'(nbeat - b0), 32'd1);
    check("R5 idle no request", 32'(mem_req), 32'h0);
    wr(A_SET, M_EN1);
    wait_mode(3, "R5 late done1 reached");
    check("R5 late beats", 32'(nbeat - b0), 32'd3);
    check("R5 late beat 1", log_addr[b0 + 1], 32'h900);
    check("R5 late beat 2", log_addr[b0 + 2], 32'h901);

    // R6/R8/R9 stalled beat and halt handshake
    wr(A_CLR, 32'hFFFFFFFF);
    wait_mode(6, "R6 halt before stall test");
    @(negedge clk); dev_ack = 1'b0;
    b0 = nbeat;
    wr(A_PER, 32'h123);
    wr(A_AD0, 32'h1000);
    wr(A_CN0, 32'h000A0004);
    wr(A_SET, 32'h00500000 | M_DIR | M_EN0);
    wr(A_SET, M_GO);
    repeat (3) @(negedge clk);
    check("R6 request pending", 32'(mem_req), 32'h1);
    check("R9 dev_req", 32'(dev_req), 32'h1);
    rd(A_SET, v); check("R6 HALT low while GO", 32'(v[6]), 32'h0);
    check("R3 high nibble in mem_addr", mem_addr, 32'hA0001000);
    check("R9 dev_addr", dev_addr, 32'h50000123);
    check("R9 mem_we in read-from-device", 32'(mem_we), 32'h1);
    check("R9 mem_wdata", mem_wdata, 32'hCAFEF00D);
    wr(A_CLR, M_DIR);
    check("R9 dev_we in write-to-device", 32'(dev_we), 32'h1);
    check("R9 dev_wdata", dev_wdata, 32'h1234ABCD);
    wr(A_CLR, M_GO);
    repeat (3) @(negedge clk);
    check("R6 request kept after GO drop", 32'(mem_req), 32'h1);
    check("R6 address stable", mem_addr, 32'hA0001000);
    rd(A_SET, v); check("R6 HALT low with beat pending", 32'(v[6]), 32'h0);
    @(negedge clk); dev_ack = 1'b1;
    @(negedge clk); dev_ack = 1'b0;
    @(negedge clk);
    check("R6 one beat then stop", 32'(nbeat - b0), 32'd1);
    check("R6 request dropped", 32'(mem_req), 32'h0);
    rd(A_SET, v); check("R6 HALT after stop", 32'(v[6]), 32'h1);
    rd(A_CN0, v); check("R8 live count", v, 32'h000A0003);
    rd(A_AD0, v); check("R8 live address", v, 32'h1001);
    rd(A_PER, v); check("R8 peripheral address", v, 32'h123);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule